// File: doc/BRIEF.md
# Streaming Snapshot Capture Buffer

This block records bursts of a valid-qualified sample stream into a dual-clock RAM. A memory-mapped host reads those samples back through a 32-bit read port that runs on its own clock. Writing happens in the stream clock domain. Each accepted beat is reduced to one 32-bit word, and the per-beat field selector decides what that word holds: the low part of the plain data word, the real part, the imaginary part, or the imaginary part packed above the real part. Only beats whose valid flag is high are stored. They go to consecutive addresses starting at zero, until every location has been written.

Once the buffer is full it stops writing and holds its contents. A full flag is carried across to the host domain. The host polls that flag and then reads the words. Its read of the final address is the trigger for the next capture: that read clears the flag and sends a re-arm request back to the stream domain, and a new fill starts at address zero. The host's read pattern therefore paces the captures. An optional sync-start mode makes each fill wait for the first valid beat that carries a sync pulse. The first fill after reset starts without any host action. Both control flags cross between the clock domains as toggles through two-flop synchronizers.

Top module: `cbuf_snapshot`

## Requirements
- R1: After reset, with sync-start off, the first DEPTH valid beats are stored at addresses 0 to DEPTH-1 in arrival order, without any host action.
- R2: A beat whose `s_valid` is low is never stored and does not advance the write address.
- R3: With `cfg_field` = 0, the stored word is bits 31:0 of `s_data`.
- R4: With `cfg_field` = 1 the word is `s_re` zero-extended. With 2 it is `s_im` zero-extended. With 3 it is `{s_im, s_re}`, with `s_re` in bits 15:0 and `s_im` in bits 31:16.
- R5: Once the buffer is full, further valid beats are not written, and the RAM contents stay unchanged until a re-arm.
- R6: `m_full` rises in the host domain within four `m_clk` cycles of the stream beat that filled the buffer. It then stays high while any address other than the last is read.
- R7: A read of address DEPTH-1 while `m_full` is high clears `m_full` on the next `m_clk` edge. The following fill starts again at address 0.
- R8: A read of address DEPTH-1 while `m_full` is low has no effect on the fill in progress.
- R9: With `cfg_sync_start` = 1, a fill skips all valid beats until one arrives with `s_sync` high. That beat is stored at address 0.
- R10: `m_rd_data` and `m_rd_valid` are updated on the `m_clk` edge that follows a cycle with `m_rd_en` high. `m_rd_valid` is low in every other cycle.
- R11: While reset is applied and right after it, `m_full` and `m_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Stream clock |
| s_rst | input | 1 | Stream-domain reset, active high |
| s_valid | input | 1 | Beat qualifier |
| s_sync | input | 1 | Sync marker for sync-start mode |
| s_data | input | DATA_W | Plain data field |
| s_re | input | PART_W | Real part of a complex sample |
| s_im | input | PART_W | Imaginary part of a complex sample |
| cfg_field | input | 2 | Stored-field selector (0 data, 1 real, 2 imag, 3 complex) |
| cfg_sync_start | input | 1 | Start each fill on a sync beat |
| m_clk | input | 1 | Host clock |
| m_rst | input | 1 | Host-domain reset, active high |
| m_rd_en | input | 1 | Read strobe |
| m_addr | input | $clog2(DEPTH) | Read word address |
| m_rd_data | output | 32 | Read word |
| m_rd_valid | output | 1 | Read word valid |
| m_full | output | 1 | Buffer holds a complete snapshot |

## Verification
Read results land one `m_clk` edge after the strobe. The bench samples them on the falling edge that follows, and it checks on that same falling edge that `m_full` has dropped after a last-word read. The full flag passes through a synchronizer, so it appears between three and four host cycles after the filling beat. The bench polls for it over a bounded window of six host cycles and reports a miss. A re-arm needs about four stream cycles to reach the fill logic. For that reason the bench idles the stream for ten stream cycles before it sends the next burst. All stimulus is applied on falling edges.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
   typedef enum logic [1:0] {
      FLD_DATA = 2'd0,
      FLD_REAL = 2'd1,
      FLD_IMAG = 2'd2,
      FLD_CPLX = 2'd3
   } field_sel_t;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_FILL = 2'd1,
      ST_FULL = 2'd2
   } fill_st_t;

   localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/cbuf_field_pick.sv
module cbuf_field_pick
   import cbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 48,
   parameter int unsigned PART_W = 16
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [PART_W-1:0] re_i,
   input  logic [PART_W-1:0] im_i,
   input  logic [1:0]        sel_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int unsigned PAD_W = WORD_W - PART_W;

   logic [WORD_W-1:0] data_w;

   generate
      if (DATA_W >= WORD_W) begin : g_trunc
         assign data_w = data_i[WORD_W-1:0];
      end else begin : g_ext
         assign data_w = {{(WORD_W-DATA_W){1'b0}}, data_i};
      end
   endgenerate

   always_comb begin
      unique case (field_sel_t'(sel_i))
         FLD_REAL: word_o = {{PAD_W{1'b0}}, re_i};
         FLD_IMAG: word_o = {{PAD_W{1'b0}}, im_i};
         FLD_CPLX: word_o = {{(WORD_W-2*PART_W){1'b0}}, im_i, re_i};
         default:  word_o = data_w;
      endcase
   end
endmodule

// File: rtl/cbuf_toggle_sync.sv
module cbuf_toggle_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tgl_i,
   output logic pulse_o
);
   logic [STAGES:0] sr;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) sr <= '0;
      else     sr <= {sr[STAGES-1:0], tgl_i};
   end

   assign pulse_o = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/cbuf_fill_ctrl.sv
module cbuf_fill_ctrl
   import cbuf_pkg::*;
#(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          valid_i,
   input  logic          sync_i,
   input  logic          sync_start_i,
   input  logic          rearm_i,
   output logic          we_o,
   output logic [AW-1:0] waddr_o,
   output logic          full_tgl_o,
   output logic          is_full_o
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   fill_st_t st;
   logic     start_ok;

   assign start_ok   = !sync_start_i || sync_i;
   assign we_o       = valid_i && ((st == ST_FILL) || ((st == ST_WAIT) && start_ok));
   assign is_full_o  = (st == ST_FULL);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st         <= ST_WAIT;
         waddr_o    <= '0;
         full_tgl_o <= 1'b0;
      end else if (rearm_i) begin
         st      <= ST_WAIT;
         waddr_o <= '0;
      end else if (we_o) begin
         if (waddr_o == LAST) begin
            st         <= ST_FULL;
            full_tgl_o <= ~full_tgl_o;
         end else begin
            st      <= ST_FILL;
            waddr_o <= waddr_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cbuf_dpram.sv
module cbuf_dpram #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned WIDTH = 32,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic             wclk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rclk,
   input  logic             rrst,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata,
   output logic             rvalid
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rclk or posedge rrst) begin
      if (rrst) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= re;
         if (re) rdata <= mem[raddr];
      end
   end
endmodule

// File: rtl/cbuf_snapshot.sv
module cbuf_snapshot
   import cbuf_pkg::*;
#(
   parameter int unsigned DEPTH       = 1024,
   parameter int unsigned DATA_W      = 48,
   parameter int unsigned PART_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic              s_clk,
   input  logic              s_rst,
   input  logic              s_valid,
   input  logic              s_sync,
   input  logic [DATA_W-1:0] s_data,
   input  logic [PART_W-1:0] s_re,
   input  logic [PART_W-1:0] s_im,
   input  logic [1:0]        cfg_field,
   input  logic              cfg_sync_start,
   input  logic              m_clk,
   input  logic              m_rst,
   input  logic              m_rd_en,
   input  logic [AW-1:0]     m_addr,
   output logic [31:0]       m_rd_data,
   output logic              m_rd_valid,
   output logic              m_full
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("cbuf_snapshot: DEPTH must be a power of two >= 2");
      end
      if (2 * PART_W > WORD_W || PART_W == 0) begin : g_bad_part
         $error("cbuf_snapshot: two PART_W fields must fit in 32 bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cbuf_snapshot: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              ram_we;
   logic [AW-1:0]     ram_waddr;
   logic [WORD_W-1:0] ram_wdata;
   logic              s_full_tgl;
   logic              s_is_full;
   logic              s_rearm_pulse;
   logic              m_full_pulse;
   logic              m_rearm_tgl;

   cbuf_field_pick #(.DATA_W(DATA_W), .PART_W(PART_W)) u_pick (
      .data_i (s_data),
      .re_i   (s_re),
      .im_i   (s_im),
      .sel_i  (cfg_field),
      .word_o (ram_wdata)
   );

   cbuf_fill_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk          (s_clk),
      .rst          (s_rst),
      .valid_i      (s_valid),
      .sync_i       (s_sync),
      .sync_start_i (cfg_sync_start),
      .rearm_i      (s_rearm_pulse),
      .we_o         (ram_we),
      .waddr_o      (ram_waddr),
      .full_tgl_o   (s_full_tgl),
      .is_full_o    (s_is_full)
   );

   cbuf_dpram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ram (
      .wclk   (s_clk),
      .we     (ram_we),
      .waddr  (ram_waddr),
      .wdata  (ram_wdata),
      .rclk   (m_clk),
      .rrst   (m_rst),
      .re     (m_rd_en),
      .raddr  (m_addr),
      .rdata  (m_rd_data),
      .rvalid (m_rd_valid)
   );

   cbuf_toggle_sync #(.STAGES(SYNC_STAGES)) u_full_sync (
      .clk     (m_clk),
      .rst     (m_rst),
      .tgl_i   (s_full_tgl),
      .pulse_o (m_full_pulse)
   );

   cbuf_toggle_sync #(.STAGES(SYNC_STAGES)) u_rearm_sync (
      .clk     (s_clk),
      .rst     (s_rst),
      .tgl_i   (m_rearm_tgl),
      .pulse_o (s_rearm_pulse)
   );

   always_ff @(posedge m_clk or posedge m_rst) begin
      if (m_rst) begin
         m_full      <= 1'b0;
         m_rearm_tgl <= 1'b0;
      end else if (m_full_pulse) begin
         m_full <= 1'b1;
      end else if (m_rd_en && (m_addr == LAST) && m_full) begin
         m_full      <= 1'b0;
         m_rearm_tgl <= ~m_rearm_tgl;
      end
   end
endmodule

// File: rtl/cbuf_snapshot_chk.sv
module cbuf_snapshot_chk #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input logic          s_clk,
   input logic          s_rst,
   input logic          s_valid,
   input logic          s_sync,
   input logic          cfg_sync_start,
   input logic          ram_we,
   input logic [AW-1:0] ram_waddr,
   input logic          s_is_full,
   input logic          m_clk,
   input logic          m_rst,
   input logic          m_rd_en,
   input logic [AW-1:0] m_addr,
   input logic          m_rd_valid,
   input logic          m_full
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   assert_valid_only_R2: assert property (@(posedge s_clk) disable iff (s_rst)
      ram_we |-> s_valid);

   assert_in_order_R1: assert property (@(posedge s_clk) disable iff (s_rst)
      (ram_we && ram_waddr != LAST) |=> (ram_waddr == $past(ram_waddr) + 1'b1));

   assert_frozen_R5: assert property (@(posedge s_clk) disable iff (s_rst)
      s_is_full |-> !ram_we);

   assert_sync_first_R9: assert property (@(posedge s_clk) disable iff (s_rst)
      (ram_we && ram_waddr == '0 && cfg_sync_start) |-> s_sync);

   assert_rd_latency_R10: assert property (@(posedge m_clk) disable iff (m_rst)
      m_rd_en |=> m_rd_valid);

   assert_rd_idle_R10: assert property (@(posedge m_clk) disable iff (m_rst)
      !m_rd_en |=> !m_rd_valid);

   assert_clear_on_last_R7: assert property (@(posedge m_clk) disable iff (m_rst)
      $fell(m_full) |-> ($past(m_rd_en) && $past(m_addr) == LAST));
endmodule

bind cbuf_snapshot cbuf_snapshot_chk #(.DEPTH(DEPTH)) u_chk (
   .s_clk          (s_clk),
   .s_rst          (s_rst),
   .s_valid        (s_valid),
   .s_sync         (s_sync),
   .cfg_sync_start (cfg_sync_start),
   .ram_we         (ram_we),
   .ram_waddr      (ram_waddr),
   .s_is_full      (s_is_full),
   .m_clk          (m_clk),
   .m_rst          (m_rst),
   .m_rd_en        (m_rd_en),
   .m_addr         (m_addr),
   .m_rd_valid     (m_rd_valid),
   .m_full         (m_full)
);

// File: tb/cbuf_snapshot_bench.sv
module cbuf_snapshot_bench;
   localparam int DEPTH  = 8;
   localparam int AW     = 3;
   localparam int DATA_W = 48;
   localparam int PART_W = 16;

   logic              s_clk = 1'b0;
   logic              m_clk = 1'b0;
   logic              s_rst = 1'b1;
   logic              m_rst = 1'b1;
   logic              s_valid = 1'b0;
   logic              s_sync = 1'b0;
   logic [DATA_W-1:0] s_data = '0;
   logic [PART_W-1:0] s_re = '0;
   logic [PART_W-1:0] s_im = '0;
   logic [1:0]        cfg_field = 2'd0;
   logic              cfg_sync_start = 1'b0;
   logic              m_rd_en = 1'b0;
   logic [AW-1:0]     m_addr = '0;
   logic [31:0]       m_rd_data;
   logic              m_rd_valid;
   logic              m_full;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   logic [31:0] exp_mem [DEPTH];

   always #4 s_clk = ~s_clk;
   always #5 m_clk = ~m_clk;

   cbuf_snapshot #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PART_W(PART_W)) u_cbuf_snapshot (
      .s_clk(s_clk), .s_rst(s_rst), .s_valid(s_valid), .s_sync(s_sync),
      .s_data(s_data), .s_re(s_re), .s_im(s_im), .cfg_field(cfg_field),
      .cfg_sync_start(cfg_sync_start), .m_clk(m_clk), .m_rst(m_rst),
      .m_rd_en(m_rd_en), .m_addr(m_addr), .m_rd_data(m_rd_data),
      .m_rd_valid(m_rd_valid), .m_full(m_full)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pick(input logic [1:0] f, input logic [DATA_W-1:0] d,
                                        input logic [15:0] re, input logic [15:0] im);
      case (f)
         2'd1:    return {16'h0, re};
         2'd2:    return {16'h0, im};
         2'd3:    return {im, re};
         default: return d[31:0];
      endcase
   endfunction

   task automatic beat(input bit v, input bit sy, input logic [1:0] f,
                       input logic [DATA_W-1:0] d, input logic [15:0] re, input logic [15:0] im);
      @(negedge s_clk);
      s_valid = v; s_sync = sy; cfg_field = f; s_data = d; s_re = re; s_im = im;
   endtask

   task automatic idle_s(input int n);
      @(negedge s_clk);
      s_valid = 1'b0; s_sync = 1'b0;
      repeat (n) @(negedge s_clk);
   endtask

   task automatic mm_read(input int a, output logic [31:0] d);
      @(negedge m_clk);
      m_rd_en = 1'b1; m_addr = AW'(a);
      @(negedge m_clk);
      m_rd_en = 1'b0;
      d = m_rd_data;
      check("R10 rd_valid", {31'h0, m_rd_valid}, 32'h1);
   endtask

   task automatic wait_full(input string req);
      bit seen = 1'b0;
      for (int i = 0; i < 6 && !seen; i++) begin
         @(negedge m_clk);
         if (m_full) seen = 1'b1;
      end
      check(req, {31'h0, seen}, 32'h1);
   endtask

   task automatic read_all(input string req);
      logic [31:0] d;
      for (int i = 0; i < DEPTH - 1; i++) begin
         mm_read(i, d);
         check(req, d, exp_mem[i]);
      end
      check("R6 full held", {31'h0, m_full}, 32'h1);
      mm_read(DEPTH - 1, d);
      check(req, d, exp_mem[DEPTH-1]);
      check("R7 full cleared", {31'h0, m_full}, 32'h0);
      idle_s(10);
   endtask

   task automatic t_reset();
      check("R11 full at reset", {31'h0, m_full}, 32'h0);
      check("R11 rd_valid at reset", {31'h0, m_rd_valid}, 32'h0);
   endtask

   task automatic t_fill_data();
      logic [31:0] d;
      for (int i = 0; i < DEPTH; i++) begin
         logic [DATA_W-1:0] v = {16'hABCD, 32'h1000_0000 + 32'(i * 17)};
         exp_mem[i] = v[31:0];
         beat(1'b0, 1'b0, 2'd0, {16'h0, 32'hDEAD_0000 + 32'(i)}, 16'h0, 16'h0);
         beat(1'b1, 1'b0, 2'd0, v, 16'h1111, 16'h2222);
      end
      idle_s(1);
      wait_full("R6 full after fill");
      for (int i = 0; i < 4; i++) beat(1'b1, 1'b0, 2'd0, 48'h0000_5555_5555, 16'h0, 16'h0);
      idle_s(3);
      mm_read(0, d);
      check("R5 frozen addr0", d, exp_mem[0]);
      mm_read(5, d);
      check("R5 frozen addr5", d, exp_mem[5]);
      read_all("R1 R2 R3 data field");
   endtask

   task automatic t_fields();
      for (int i = 0; i < DEPTH; i++) begin
         logic [1:0]  f  = (i < 2) ? 2'd1 : (i < 4) ? 2'd2 : 2'd3;
         logic [15:0] re = 16'h8100 + 16'(i);
         logic [15:0] im = 16'h4200 + 16'(i * 3);
         logic [DATA_W-1:0] dd = 48'hFFFF_FFFF_FFFF;
         exp_mem[i] = pick(f, dd, re, im);
         beat(1'b1, 1'b0, f, dd, re, im);
      end
      idle_s(1);
      wait_full("R6 full after field fill");
      read_all("R4 field select");
   endtask

   task automatic t_last_not_full();
      logic [31:0] d;
      for (int i = 0; i < 3; i++) begin
         exp_mem[i] = 32'h3300_0000 + 32'(i);
         beat(1'b1, 1'b0, 2'd0, {16'h0, exp_mem[i]}, 16'h0, 16'h0);
      end
      idle_s(1);
      mm_read(DEPTH - 1, d);
      check("R8 no full yet", {31'h0, m_full}, 32'h0);
      idle_s(10);
      for (int i = 3; i < DEPTH; i++) begin
         exp_mem[i] = 32'h3300_0000 + 32'(i);
         beat(1'b1, 1'b0, 2'd0, {16'h0, exp_mem[i]}, 16'h0, 16'h0);
      end
      idle_s(1);
      wait_full("R8 fill continued to full");
      read_all("R8 contents kept");
   endtask

   task automatic t_sync();
      @(negedge s_clk);
      cfg_sync_start = 1'b1;
      for (int i = 0; i < 3; i++) beat(1'b1, 1'b0, 2'd0, 48'h0000_0BAD_0000 + 48'(i), 16'h0, 16'h0);
      beat(1'b0, 1'b1, 2'd0, 48'h0000_0BAD_00FF, 16'h0, 16'h0);
      for (int i = 0; i < DEPTH; i++) begin
         exp_mem[i] = 32'h5900_0000 + 32'(i);
         beat(1'b1, (i == 0), 2'd0, {16'h0, exp_mem[i]}, 16'h0, 16'h0);
      end
      idle_s(1);
      wait_full("R9 full after sync fill");
      read_all("R9 sync start");
      @(negedge s_clk);
      cfg_sync_start = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge m_clk);
      t_reset();
      @(negedge s_clk);
      s_rst = 1'b0; m_rst = 1'b0;
      @(negedge m_clk);
      check("R11 full after reset", {31'h0, m_full}, 32'h0);
      check("R11 rd_valid after reset", {31'h0, m_rd_valid}, 32'h0);
      t_fill_data();
      t_fields();
      t_last_not_full();
      t_sync();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge s_clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule